// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a lockstep thread group are enabled while control flow splits and joins. Each conditional branch arrives with one predicate bit per lane and three program counters: the taken target, the fall-through target and the point where the two paths join again. Only the predicate bits of lanes that are currently enabled count. When all of those lanes agree, the branch is handled for the whole group at once. The path that no lane needs is never visited, and the enabled set stays as it was.

When the enabled lanes disagree, the block saves the current enabled set, the taken subset and the two remaining program counters on a hardware stack. It then runs the taken path with only the taken lanes enabled. An else-switch event later enables the lanes that did not take the branch and steers to the fall-through target. A reconverge event pops the entry, restores the saved set and steers to the join point. Nesting works in last-in, first-out order up to a configurable depth. Pushing onto a full stack and popping from an empty one are both recorded in sticky error flags.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask has every lane set, next_pc equals the RESET_PC parameter, and both error flags are 0.
- R2: On a branch event where every enabled lane has its predicate bit at 1, next_pc becomes the taken target, the active mask is unchanged and nothing is pushed.
- R3: On a branch event where no enabled lane has its predicate bit at 1, and at least one lane is enabled, next_pc becomes the fall-through target, the active mask is unchanged and nothing is pushed.
- R4: Predicate bits of lanes that are disabled when the branch arrives have no effect on the uniform/divergent decision or on the resulting mask.
- R5: On a divergent branch, meaning some enabled lanes are 1 and some are 0, one entry is pushed. The active mask becomes the enabled lanes whose predicate is 1, and next_pc becomes the taken target.
- R6: An else-switch event with a non-empty stack sets the active mask to the top entry's saved mask AND NOT its taken subset, and sets next_pc to that entry's fall-through target. The entry stays on the stack.
- R7: A reconverge event with a non-empty stack pops the top entry, restores its saved mask and sets next_pc to its join target. Nested entries are released in last-in, first-out order.
- R8: A divergent branch while DEPTH entries are held sets the sticky overflow flag and leaves the mask, next_pc and the stack unchanged.
- R9: An else-switch or reconverge event on an empty stack sets the sticky underflow flag and leaves the mask and next_pc unchanged.
- R10: When several events are asserted in one cycle, only one is acted on, with priority branch, then else-switch, then reconverge. In a cycle with no event, the mask and next_pc hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Conditional branch event |
| br_pred | input | LANES | Per-lane branch condition |
| br_taken_pc | input | PC_W | Target of the taken path |
| br_fall_pc | input | PC_W | Target of the not-taken path |
| br_join_pc | input | PC_W | Point where the paths join |
| else_valid | input | 1 | Switch to the not-taken path of the top entry |
| join_valid | input | 1 | Reconverge: pop the top entry |
| active_mask | output | LANES | Lanes enabled for the next instruction |
| next_pc | output | PC_W | Program counter to fetch next |
| overflow_err | output | 1 | Sticky: push attempted on a full stack |
| underflow_err | output | 1 | Sticky: else or reconverge on an empty stack |

## Verification
Predicates are drawn from several groups, and each group separates a different outcome. All-ones and all-zeros separate taken-uniform from skipped-uniform. Patterns that differ from the active mask only in disabled lanes show whether disabled lanes are wrongly counted. Half-and-half splits, and fully random words under nested masks, force divergence and exercise the last-in, first-out restore. Long runs of divergent branches, and pops right after reset, reach both stack limits. Simultaneous events show whether the priority order holds.

// File: rtl/simt_pkg.sv
package simt_pkg;
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_BRANCH = 2'd1,
        EV_ELSE   = 2'd2,
        EV_JOIN   = 2'd3
    } simt_ev_e;

    // Fixed priority: branch, then else-switch, then reconverge.
    function automatic simt_ev_e pick_event(input logic br, input logic els, input logic jn);
        if (br)       return EV_BRANCH;
        else if (els) return EV_ELSE;
        else if (jn)  return EV_JOIN;
        else          return EV_NONE;
    endfunction
endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] eff,
    output logic             all_taken,
    output logic             none_taken,
    output logic             diverge
);
    always_comb begin
        eff        = active & pred;
        all_taken  = (eff == active);
        none_taken = (eff == '0) && (active != '0);
        diverge    = !all_taken && !none_taken;
    end
endmodule

// File: rtl/simt_entry_stack.sv
module simt_entry_stack #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int SP_W = $clog2(DEPTH + 1);

    logic [SP_W-1:0] sp_d, sp_q;
    logic [W-1:0]    slot_q [DEPTH];

    always_comb begin
        sp_d  = sp_q;
        empty = (sp_q == '0);
        full  = (sp_q == SP_W'(DEPTH));
        if (push && !full)       sp_d = sp_q + 1'b1;
        else if (pop && !empty)  sp_d = sp_q - 1'b1;
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SP_W'(i + 1)) rdata = slot_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && sp_q == SP_W'(g)) slot_q[g] <= wdata;
        end
    end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
    parameter int              LANES    = 32,
    parameter int              PC_W     = 32,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_pred,
    input  logic [PC_W-1:0]  br_taken_pc,
    input  logic [PC_W-1:0]  br_fall_pc,
    input  logic [PC_W-1:0]  br_join_pc,
    input  logic             else_valid,
    input  logic             join_valid,
    output logic [LANES-1:0] active_mask,
    output logic [PC_W-1:0]  next_pc,
    output logic             overflow_err,
    output logic             underflow_err
);
    import simt_pkg::*;

    typedef struct packed {
        logic [LANES-1:0] saved;
        logic [LANES-1:0] taken;
        logic [PC_W-1:0]  fall_pc;
        logic [PC_W-1:0]  join_pc;
    } entry_t;

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  pc;
        logic             ovf;
        logic             unf;
    } state_t;

    localparam int EW = $bits(entry_t);

    state_t           st_d, st_q;
    entry_t           push_ent, top_ent;
    logic [EW-1:0]    top_raw;
    logic             push, pop, stk_empty, stk_full;
    logic [LANES-1:0] eff;
    logic             all_taken, none_taken, diverge;
    simt_ev_e         ev;

    simt_br_classify #(.LANES(LANES)) i_classify (
        .active     (st_q.mask),
        .pred       (br_pred),
        .eff        (eff),
        .all_taken  (all_taken),
        .none_taken (none_taken),
        .diverge    (diverge)
    );

    simt_entry_stack #(.W(EW), .DEPTH(DEPTH)) i_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (push_ent),
        .rdata (top_raw),
        .empty (stk_empty),
        .full  (stk_full)
    );

    always_comb begin
        top_ent  = entry_t'(top_raw);
        ev       = pick_event(br_valid, else_valid, join_valid);
        st_d     = st_q;
        push     = 1'b0;
        pop      = 1'b0;
        push_ent = '{saved: st_q.mask, taken: eff, fall_pc: br_fall_pc, join_pc: br_join_pc};
        unique case (ev)
            EV_BRANCH: begin
                if (all_taken) begin
                    st_d.pc = br_taken_pc;
                end else if (none_taken) begin
                    st_d.pc = br_fall_pc;
                end else if (diverge && stk_full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    push      = 1'b1;
                    st_d.mask = eff;
                    st_d.pc   = br_taken_pc;
                end
            end
            EV_ELSE: begin
                if (stk_empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.mask = top_ent.saved & ~top_ent.taken;
                    st_d.pc   = top_ent.fall_pc;
                end
            end
            EV_JOIN: begin
                if (stk_empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    pop       = 1'b1;
                    st_d.mask = top_ent.saved;
                    st_d.pc   = top_ent.join_pc;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mask: '1, pc: RESET_PC, ovf: 1'b0, unf: 1'b0};
        else        st_q <= st_d;
    end

    assign active_mask   = st_q.mask;
    assign next_pc       = st_q.pc;
    assign overflow_err  = st_q.ovf;
    assign underflow_err = st_q.unf;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_pred,
    input logic [PC_W-1:0]  br_taken_pc,
    input logic [PC_W-1:0]  br_fall_pc,
    input logic             else_valid,
    input logic             join_valid,
    input logic [LANES-1:0] active_mask,
    input logic [PC_W-1:0]  next_pc,
    input logic             overflow_err,
    input logic             underflow_err
);
    p_uniform_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && ((br_pred & active_mask) == active_mask)
        |=> active_mask == $past(active_mask) && next_pc == $past(br_taken_pc));

    p_uniform_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && ((br_pred & active_mask) == '0) && (active_mask != '0)
        |=> active_mask == $past(active_mask) && next_pc == $past(br_fall_pc));

    p_diverge_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (active_mask & ~$past(active_mask)) == '0);

    p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    p_no_underflow_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid && !else_valid && !join_valid
        |=> $stable(active_mask) && $stable(next_pc));
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .PC_W(PC_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .br_valid      (br_valid),
    .br_pred       (br_pred),
    .br_taken_pc   (br_taken_pc),
    .br_fall_pc    (br_fall_pc),
    .else_valid    (else_valid),
    .join_valid    (join_valid),
    .active_mask   (active_mask),
    .next_pc       (next_pc),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err)
);

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
    localparam int          D    = 8;
    localparam logic [31:0] RPC  = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, else_valid = 1'b0, join_valid = 1'b0;
    logic [31:0] br_pred = '0, br_taken_pc = '0, br_fall_pc = '0, br_join_pc = '0;
    logic [31:0] active_mask, next_pc;
    logic        overflow_err, underflow_err;

    int n_chk = 0, n_bad = 0;

    // Reference state
    logic [31:0] m_mask, m_pc;
    logic        m_ovf, m_unf;
    int          m_sp;
    logic [31:0] m_saved [D];
    logic [31:0] m_taken [D];
    logic [31:0] m_fpc   [D];
    logic [31:0] m_jpc   [D];

    always #4 clk = ~clk;

    simt_mask_stack #(.LANES(32), .PC_W(32), .DEPTH(D), .RESET_PC(RPC)) i_simt_mask_stack (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
        .br_taken_pc(br_taken_pc), .br_fall_pc(br_fall_pc), .br_join_pc(br_join_pc),
        .else_valid(else_valid), .join_valid(join_valid), .active_mask(active_mask),
        .next_pc(next_pc), .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk({req, " mask"}, active_mask, m_mask);
        chk({req, " pc"}, next_pc, m_pc);
        chk({req, " err"}, {30'd0, overflow_err, underflow_err}, {30'd0, m_ovf, m_unf});
    endtask

    task automatic model_reset();
        m_mask = '1; m_pc = RPC; m_ovf = 1'b0; m_unf = 1'b0; m_sp = 0;
    endtask

    task automatic model_step(input bit b, input bit e, input bit j, input logic [31:0] p,
                              input logic [31:0] tp, input logic [31:0] fp, input logic [31:0] jp);
        logic [31:0] eff;
        eff = p & m_mask;
        if (b) begin
            if (eff == m_mask) m_pc = tp;
            else if (eff == 0) m_pc = fp;
            else if (m_sp == D) m_ovf = 1'b1;
            else begin
                m_saved[m_sp] = m_mask; m_taken[m_sp] = eff;
                m_fpc[m_sp] = fp; m_jpc[m_sp] = jp; m_sp++;
                m_mask = eff; m_pc = tp;
            end
        end else if (e) begin
            if (m_sp == 0) m_unf = 1'b1;
            else begin
                m_mask = m_saved[m_sp-1] & ~m_taken[m_sp-1];
                m_pc = m_fpc[m_sp-1];
            end
        end else if (j) begin
            if (m_sp == 0) m_unf = 1'b1;
            else begin
                m_sp--;
                m_mask = m_saved[m_sp]; m_pc = m_jpc[m_sp];
            end
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input bit b, input bit e, input bit j, input logic [31:0] p,
                        input logic [31:0] tp, input logic [31:0] fp, input logic [31:0] jp);
        br_valid = b; else_valid = e; join_valid = j;
        br_pred = p; br_taken_pc = tp; br_fall_pc = fp; br_join_pc = jp;
        model_step(b, e, j, p, tp, fp, jp);
        @(posedge clk);
        @(negedge clk);
        br_valid = 1'b0; else_valid = 1'b0; join_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        cmp_all("R1");

        step(1, 0, 0, 32'hFFFF_FFFF, 32'h10, 32'h14, 32'h18); cmp_all("R2 all-ones");
        step(1, 0, 0, 32'h0000_0000, 32'h20, 32'h24, 32'h28); cmp_all("R3 all-zeros");
        step(1, 0, 0, 32'h0000_FFFF, 32'h30, 32'h34, 32'h38);
        cmp_all("R5 split");
        chk("R5 mask", active_mask, 32'h0000_FFFF);
        step(1, 0, 0, 32'hABCD_FFFF, 32'h40, 32'h44, 32'h48); cmp_all("R4 taken ignore");
        chk("R4 pc", next_pc, 32'h40);
        step(1, 0, 0, 32'hFFFF_0000, 32'h50, 32'h54, 32'h58); cmp_all("R4 skip ignore");
        chk("R4 skip pc", next_pc, 32'h54);
        step(1, 0, 0, 32'h1234_00F0, 32'h60, 32'h64, 32'h68); cmp_all("R5 nested");
        step(0, 1, 0, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R6 inner else");
        chk("R6 mask", active_mask, 32'h0000_FF0F);
        step(0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R7 inner join");
        step(0, 1, 0, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R6 outer else");
        chk("R6 outer mask", active_mask, 32'hFFFF_0000);
        step(0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R7 outer join");
        chk("R7 pc", next_pc, 32'h38);
        step(0, 0, 0, 32'h5, 32'h1, 32'h2, 32'h3); cmp_all("R10 idle");
        step(1, 1, 1, 32'h00FF_00FF, 32'h70, 32'h74, 32'h78); cmp_all("R10 branch wins");
        step(0, 1, 1, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R10 else over join");
        chk("R10 mask", active_mask, 32'hFF00_FF00);
        step(0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R7 pop");

        // Underflow after reset
        do_reset();
        step(0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R9 join empty");
        chk("R9 flag", {31'd0, underflow_err}, 32'd1);
        do_reset();
        step(0, 1, 0, 32'h0, 32'h0, 32'h0, 32'h0); cmp_all("R9 else empty");

        // Overflow: peel one lane per level
        do_reset();
        for (int k = 0; k <= D; k++) begin
            step(1, 0, 0, ~(32'h1 << k) & m_mask, 32'h200 + k, 32'h300 + k, 32'h400 + k);
            cmp_all("R8 fill");
        end
        chk("R8 flag", {31'd0, overflow_err}, 32'd1);
        for (int k = 0; k < D; k++) begin
            step(0, 0, 1, 32'h0, 32'h0, 32'h0, 32'h0);
            cmp_all("R7 drain");
        end
        chk("R7 full restore", active_mask, 32'hFFFF_FFFF);

        // Mixed sweep against the reference model
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int c = 0; c < 2000; c++) begin
                int  sel;
                logic [31:0] p;
                bit b, e, j;
                sel = $urandom % 10;
                b = (sel < 4); e = (sel == 4 || sel == 5 || sel == 9);
                j = (sel >= 6);
                case ($urandom % 5)
                    0: p = '1;
                    1: p = '0;
                    2: p = m_mask | $urandom;
                    3: p = ~m_mask & $urandom;
                    default: p = $urandom;
                endcase
                step(b, e, j, p, $urandom, $urandom, $urandom);
                cmp_all("R10 sweep");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule